// File: doc/BRIEF.md
# Variable Page Size Translation Buffer

This block is a fully associative address translation buffer. Every entry holds its own page size code, so pages of 1 KB, 4 KB, 16 KB and so on up to 16 MB can sit side by side in the same buffer. Software loads and inspects entries through an indexed write port and an indexed read port. Each entry is reached as three 32-bit words: a match word, a translation word and an ID word.

A search port takes a 32-bit effective address and a process ID. Every entry compares against them in parallel, with the compare masked by that entry's size code. The block reports a hit flag, the index of the lowest-numbered matching entry, the physical address and the entry's permission, storage-attribute and user bits. An entry with an ID of zero matches every process. Clearing an entry's valid bit removes the entry from all searches.

Top module: `vtlb_top`

## Requirements
- R1: Size code s (0..7) gives a page of 1024 << (2*s) bytes. The low 2*s bits of the stored effective and real page numbers are ignored, so an address one byte past a page's end misses, and code 7 spans 16 MB.
- R2: An entry takes part in a search only while its valid bit is set. A write that clears the bit makes later searches that would have hit it miss, or fall through to another entry.
- R3: An entry with ID zero matches any process ID. An entry with a nonzero ID matches only an equal process ID.
- R4: On a hit, the physical address takes the entry's real page number bits above the page offset and the effective address bits inside the page offset.
- R5: The hit flag is set when any entry matches. When several entries match, the index reported is the lowest-numbered one.
- R6: A write changes search results from the clock cycle after its edge. A search issued in the same cycle as the write sees the old contents.
- R7: The word select codes are 0 for the match word, 1 for the translation word and 2 for the ID word.
  - Match word: effective page number in bits 31:10, valid in bit 9, size code in bits 8:6, user bit in bit 5. Bits 4:0 are not stored and read as zero.
  - Translation word: real page number in bits 31:10, permission in bits 9:4 (bit 9 execute, bit 8 write, bits 7:4 zone select), storage attributes in bits 3:0.
  - ID word: the ID in its low bits, zero above.
  - The read port returns the stored fields of the selected word combinationally.
- R8: After reset every entry is invalid and all fields are zero. Every search misses and every read returns zero.
- R9: On a hit the block reports the matching entry's permission, storage attribute and user bits. On a miss the physical address and those fields are zero, and the index has no meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Word select for the write |
| wr_idx | input | IDXW | Entry written |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Word select for the read |
| rd_idx | input | IDXW | Entry read |
| rd_data | output | 32 | Read data |
| srch_ea | input | 32 | Effective address searched |
| srch_pid | input | TIDW | Current process ID |
| srch_hit | output | 1 | A valid entry matched |
| srch_idx | output | IDXW | Lowest matching entry |
| srch_pa | output | 32 | Translated physical address |
| srch_perm | output | 6 | Permission bits of the hit |
| srch_wimg | output | 4 | Storage attribute bits of the hit |
| srch_uattr | output | 1 | User attribute bit of the hit |

## Verification
The bench uses the default parameters: 64 entries and an 8-bit ID. With these values the top index, 63, can be used in a priority contest against a lower entry. The largest size code can also map a 16 MB page across most of the compared page-number bits. Holding the ID at 8 bits lets both the zero wildcard and a nonzero mismatch be exercised directly.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int PN_W  = 22;
  localparam int OFS_W = 10;

  typedef enum logic [1:0] {
    SEL_HI  = 2'd0,
    SEL_LO  = 2'd1,
    SEL_TID = 2'd2
  } vtlb_sel_e;

  typedef struct packed {
    logic            valid;
    logic [2:0]      size;
    logic [PN_W-1:0] epn;
    logic            uattr;
    logic [PN_W-1:0] rpn;
    logic [5:0]      perm;
    logic [3:0]      wimg;
  } vtlb_ent_t;

  // page-number bits that take part in compare for a size code
  function automatic logic [PN_W-1:0] keep_mask(input logic [2:0] size);
    return {PN_W{1'b1}} << {size, 1'b0};
  endfunction

  function automatic logic pn_equal(input logic [PN_W-1:0] epn,
                                    input logic [2:0] size,
                                    input logic [PN_W-1:0] ea_pn);
    return ((epn ^ ea_pn) & keep_mask(size)) == '0;
  endfunction

  function automatic logic [31:0] xlate(input logic [PN_W-1:0] rpn,
                                        input logic [2:0] size,
                                        input logic [31:0] ea);
    logic [PN_W-1:0] m;
    m = keep_mask(size);
    return {(rpn & m) | (ea[31:OFS_W] & ~m), ea[OFS_W-1:0]};
  endfunction
endpackage

// File: rtl/vtlb_store.sv
module vtlb_store
  import vtlb_pkg::*;
#(
  parameter int N    = 64,
  parameter int TIDW = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [31:0]     wr_data,
  input  logic [1:0]      rd_sel,
  input  logic [IDXW-1:0] rd_idx,
  output logic [31:0]     rd_data,
  output vtlb_ent_t       ent_o [N],
  output logic [TIDW-1:0] tid_o [N]
);
  vtlb_ent_t       ent_q [N];
  logic [TIDW-1:0] tid_q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    wire sel_me = wr_en && (wr_idx == IDXW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
        tid_q[i] <= '0;
      end else if (sel_me) begin
        case (wr_sel)
          SEL_HI: begin
            ent_q[i].epn   <= wr_data[31:OFS_W];
            ent_q[i].valid <= wr_data[9];
            ent_q[i].size  <= wr_data[8:6];
            ent_q[i].uattr <= wr_data[5];
          end
          SEL_LO: begin
            ent_q[i].rpn  <= wr_data[31:OFS_W];
            ent_q[i].perm <= wr_data[9:4];
            ent_q[i].wimg <= wr_data[3:0];
          end
          SEL_TID: tid_q[i] <= wr_data[TIDW-1:0];
          default: ;
        endcase
      end
    end
    assign ent_o[i] = ent_q[i];
    assign tid_o[i] = tid_q[i];
  end

  vtlb_ent_t rd_ent;
  always_comb begin
    rd_ent  = ent_q[rd_idx];
    rd_data = '0;
    case (rd_sel)
      SEL_HI:  rd_data = {rd_ent.epn, rd_ent.valid, rd_ent.size, rd_ent.uattr, 5'b0};
      SEL_LO:  rd_data = {rd_ent.rpn, rd_ent.perm, rd_ent.wimg};
      SEL_TID: rd_data = 32'(tid_q[rd_idx]);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int N    = 64,
  parameter int TIDW = 8
) (
  input  vtlb_ent_t       ent [N],
  input  logic [TIDW-1:0] tid [N],
  input  logic [31:0]     ea,
  input  logic [TIDW-1:0] pid,
  output logic [N-1:0]    hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    wire id_ok = (tid[i] == '0) || (tid[i] == pid);
    assign hit_vec[i] = ent[i].valid && id_ok &&
                        pn_equal(ent[i].epn, ent[i].size, ea[31:OFS_W]);
  end
endmodule

// File: rtl/vtlb_prio.sv
module vtlb_prio #(
  parameter int N = 64,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    vec,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDXW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
  import vtlb_pkg::*;
#(
  parameter int N    = 64,
  parameter int TIDW = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [31:0]     wr_data,
  input  logic [1:0]      rd_sel,
  input  logic [IDXW-1:0] rd_idx,
  output logic [31:0]     rd_data,
  input  logic [31:0]     srch_ea,
  input  logic [TIDW-1:0] srch_pid,
  output logic            srch_hit,
  output logic [IDXW-1:0] srch_idx,
  output logic [31:0]     srch_pa,
  output logic [5:0]      srch_perm,
  output logic [3:0]      srch_wimg,
  output logic            srch_uattr
);
  vtlb_ent_t       ent [N];
  logic [TIDW-1:0] tid [N];
  logic [N-1:0]    match_vec;
  logic            any_hit;
  logic [IDXW-1:0] win_idx;
  vtlb_ent_t       win;

  vtlb_store #(.N(N), .TIDW(TIDW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .ent_o(ent), .tid_o(tid)
  );

  vtlb_match #(.N(N), .TIDW(TIDW)) u_match (
    .ent(ent), .tid(tid), .ea(srch_ea), .pid(srch_pid), .hit_vec(match_vec)
  );

  vtlb_prio #(.N(N)) u_prio (
    .vec(match_vec), .any(any_hit), .idx(win_idx)
  );

  assign win        = ent[win_idx];
  assign srch_hit   = any_hit;
  assign srch_idx   = win_idx;
  assign srch_pa    = any_hit ? xlate(win.rpn, win.size, srch_ea) : '0;
  assign srch_perm  = any_hit ? win.perm  : '0;
  assign srch_wimg  = any_hit ? win.wimg  : '0;
  assign srch_uattr = any_hit ? win.uattr : 1'b0;
endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk #(
  parameter int N = 64,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [IDXW-1:0] wr_idx,
  input logic [31:0]     wr_data,
  input logic [31:0]     srch_ea,
  input logic [31:0]     srch_pa,
  input logic            srch_hit,
  input logic [IDXW-1:0] srch_idx,
  input logic [5:0]      srch_perm,
  input logic [N-1:0]    match_vec
);
  logic [N-1:0] below;
  assign below = (N'(1) << srch_idx) - N'(1);

  p_hit_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit == (match_vec != '0));

  p_hit_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> match_vec[srch_idx]);

  p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> ((match_vec & below) == '0));

  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> (srch_pa[9:0] == srch_ea[9:0]));

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_hit |-> (srch_pa == '0 && srch_perm == '0));

  p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && !wr_data[9] && int'(wr_idx) < N)
      |=> !match_vec[$past(wr_idx)]);
endmodule

bind vtlb_top vtlb_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_idx(wr_idx), .wr_data(wr_data), .srch_ea(srch_ea),
  .srch_pa(srch_pa), .srch_hit(srch_hit), .srch_idx(srch_idx),
  .srch_perm(srch_perm), .match_vec(match_vec)
);

// File: tb/vtlb_top_tb.sv
`timescale 1ns/1ps
module vtlb_top_tb;
  localparam int N = 64;
  localparam int TIDW = 8;
  localparam int IDXW = 6;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [IDXW-1:0] wr_idx = 0, rd_idx = 0, srch_idx;
  logic [31:0] wr_data = 0, rd_data, srch_ea = 0, srch_pa;
  logic [TIDW-1:0] srch_pid = 0;
  logic srch_hit, srch_uattr;
  logic [5:0] srch_perm;
  logic [3:0] srch_wimg;

  always #2 clk = ~clk;

  vtlb_top #(.N(N), .TIDW(TIDW)) u_dut (.*);

  typedef struct packed {
    logic hit; logic [IDXW-1:0] idx; logic [31:0] pa;
    logic [5:0] perm; logic [3:0] wimg; logic ua;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  logic        m_v [N];
  logic [2:0]  m_sz [N];
  logic [21:0] m_epn [N], m_rpn [N];
  logic        m_ua [N];
  logic [5:0]  m_perm [N];
  logic [3:0]  m_wimg [N];
  logic [7:0]  m_tid [N];

  function automatic res_t model_find(logic [31:0] ea, logic [7:0] pid);
    res_t r;
    longint unsigned bytes, base, pbase;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (!r.hit && m_v[i] && (m_tid[i] == 0 || m_tid[i] == pid)) begin
        bytes = 64'd1024 << (2 * m_sz[i]);
        base  = {32'd0, m_epn[i], 10'd0} & ~(bytes - 1);
        pbase = {32'd0, m_rpn[i], 10'd0} & ~(bytes - 1);
        if (64'(ea) >= base && 64'(ea) < base + bytes) begin
          r.hit = 1; r.idx = IDXW'(i);
          r.pa = 32'(pbase | (64'(ea) & (bytes - 1)));
          r.perm = m_perm[i]; r.wimg = m_wimg[i]; r.ua = m_ua[i];
        end
      end
    end
    return r;
  endfunction

  function automatic void model_write(int idx, logic [1:0] sel, logic [31:0] d);
    case (sel)
      2'd0: begin m_epn[idx] = d[31:10]; m_v[idx] = d[9]; m_sz[idx] = d[8:6]; m_ua[idx] = d[5]; end
      2'd1: begin m_rpn[idx] = d[31:10]; m_perm[idx] = d[9:4]; m_wimg[idx] = d[3:0]; end
      2'd2: m_tid[idx] = d[7:0];
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] hiw(logic [31:0] a, bit v, logic [2:0] sz, bit ua);
    return {a[31:10], v, sz, ua, 5'b0};
  endfunction
  function automatic logic [31:0] low(logic [31:0] a, logic [5:0] p, logic [3:0] w);
    return {a[31:10], p, w};
  endfunction

  task automatic check(string req, bit ok, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(int idx, logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = IDXW'(idx); wr_sel = sel; wr_data = d;
    model_write(idx, sel, d);
    @(posedge clk); #0.5;
    wr_en = 0;
  endtask

  task automatic load(int idx, logic [7:0] t, logic [31:0] lo_w, logic [31:0] hi_w);
    wr_word(idx, 2'd2, 32'(t));
    wr_word(idx, 2'd1, lo_w);
    wr_word(idx, 2'd0, hi_w);
  endtask

  task automatic search(logic [31:0] ea, logic [7:0] pid, string tag);
    @(negedge clk);
    srch_ea = ea; srch_pid = pid;
    exp_q.push_back(model_find(ea, pid));
    tag_q.push_back(tag);
  endtask

  task automatic rd_chk(int idx, logic [1:0] sel, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_idx = IDXW'(idx); rd_sel = sel;
    #1;
    check(tag, rd_data === exp, 128'(rd_data), 128'(exp));
  endtask

  // monitor: compare each issued search just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        res_t e, a;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        a = '{hit: srch_hit, idx: srch_idx, pa: srch_pa, perm: srch_perm,
              wimg: srch_wimg, ua: srch_uattr};
        if (!e.hit) a.idx = '0;
        check(t, a === e, 128'(a), 128'(e));
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_sz[i] = 0; m_epn[i] = 0; m_rpn[i] = 0;
      m_ua[i] = 0; m_perm[i] = 0; m_wimg[i] = 0; m_tid[i] = 0;
    end
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;

    // R8: reset state
    search(32'h0000_0000, 8'h00, "R8 search after reset");
    rd_chk(5, 2'd0, 32'h0, "R8 read hi after reset");
    rd_chk(63, 2'd1, 32'h0, "R8 read lo after reset");

    // entry 3: 1 KB page, ID 0x12
    load(3, 8'h12, low(32'h8000_0000, 6'b10_0101, 4'hA), hiw(32'h0001_0000, 1, 3'd0, 1));
    search(32'h0001_0123, 8'h12, "R4 R9 1KB hit");
    search(32'h0001_0123, 8'h13, "R3 ID mismatch");
    search(32'h0001_0400, 8'h12, "R1 past 1KB end");
    search(32'h0001_03FF, 8'h12, "R1 last byte of 1KB");

    // entry 10: 16 MB page, wildcard ID, junk in ignored page-number bits
    load(10, 8'h00, low(32'h4012_3400, 6'b01_1111, 4'h5), hiw(32'h0234_5400, 1, 3'd7, 0));
    search(32'h02AB_CDEF, 8'h55, "R1 R3 R4 16MB wildcard");
    search(32'h0200_0001, 8'hFF, "R1 16MB low edge");
    search(32'h0300_0000, 8'h00, "R1 past 16MB end");
    rd_chk(10, 2'd0, 32'h0234_5400 | 32'h3C0, "R7 read hi");
    rd_chk(10, 2'd1, low(32'h4012_3400, 6'b01_1111, 4'h5), "R7 read lo");
    rd_chk(3, 2'd2, 32'h12, "R7 read id");

    // priority between entry 20 and entry 63, 4 KB pages
    load(63, 8'h00, low(32'h7000_0000, 6'h01, 4'h1), hiw(32'h0005_0000, 1, 3'd1, 0));
    search(32'h0005_0ABC, 8'h01, "R5 only entry 63");
    load(20, 8'h07, low(32'h6000_0000, 6'h02, 4'h2), hiw(32'h0005_0000, 1, 3'd1, 1));
    search(32'h0005_0ABC, 8'h07, "R5 lowest index wins");
    search(32'h0005_0FFF, 8'h09, "R3 R5 ID excludes 20");
    wr_word(20, 2'd0, hiw(32'h0005_0000, 0, 3'd1, 1));
    search(32'h0005_0ABC, 8'h07, "R2 cleared entry falls through");
    wr_word(63, 2'd0, hiw(32'h0005_0000, 0, 3'd1, 0));
    search(32'h0005_0ABC, 8'h07, "R2 all cleared miss");

    // R6: write and search in the same cycle, then the next cycle
    @(negedge clk);
    wr_en = 1; wr_idx = 6'd30; wr_sel = 2'd0; wr_data = hiw(32'h0900_0000, 1, 3'd2, 0);
    srch_ea = 32'h0900_1234; srch_pid = 8'h00;
    exp_q.push_back(model_find(32'h0900_1234, 8'h00));
    tag_q.push_back("R6 same cycle sees old");
    model_write(30, 2'd0, hiw(32'h0900_0000, 1, 3'd2, 0));
    @(posedge clk); #0.5 wr_en = 0;
    search(32'h0900_1234, 8'h00, "R6 next cycle sees new");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule